// File: doc/BRIEF.md
# Fixed-Point Biquad Filter Section

This block is one second-order recursive filter section for streamed audio. Each accepted sample is combined with the two previous inputs and the two previous outputs through five signed coefficients. A single 32x32 multiplier is shared over five cycles, and the products go into a 64-bit saturating accumulator. Samples and coefficients are signed fractions with 31 fractional bits. Coefficients of magnitude one or more are loaded divided by 2, 4 or 8. A programmable left shift, applied once when the accumulator is converted back to a sample, restores the true gain.

Samples enter either as full 32-bit words or as 16-bit words that are moved up into the top half. The result leaves as a 16-bit or 24-bit value, sign-extended to 32 bits. Coefficients and the scale shift are written through a simple write port. That port only acts while the section is waiting for a sample. A history clear input restarts the filter state without reloading coefficients. An accumulator overflow saturates instead of wrapping and sets a sticky flag.

Top module: `biquad_section`

## Requirements
- R1: With `in_narrow`=0 the sample is `in_data` unchanged. With `in_narrow`=1 the sample is `in_data[15:0]` placed in bits 31:16 with bits 15:0 zero. The mode is taken at the accepting edge.
- R2: Coefficients and samples are signed with 31 fractional bits. For each sample the accumulator starts at zero and takes, in order, +b0·x0, +b1·x1, +b2·x2, −a1·y1, −a2·y2. Each product is a full 64-bit product.
- R3: If any accumulate step leaves the signed 64-bit range, the accumulator clamps to the nearest 64-bit limit and `ovf` goes high. `ovf` then stays high until `rst`; `clr_hist` does not clear it.
- R4: The 32-bit result is floor(acc·2^k / 2^31), with k the scale field (0..3). A result outside the signed 32-bit range clamps to 0x7FFFFFFF or 0x80000000.
- R5: With `out_q23`=0 (taken at the accepting edge), `out_data` is the 32-bit result arithmetically shifted right by 16. With `out_q23`=1 it is shifted right by 8.
- R6: After each sample the history moves: x2←x1, x1←x0, y2←y1, y1←the clamped 32-bit result before the output reduction.
- R7: `in_ready` is high only when idle. A sample is taken on an edge where `in_valid` and `in_ready` are both high. `out_valid` rises on the sixth rising edge after that edge. `out_data` holds while `out_ready` is low, and `in_ready` returns on the edge after `out_valid && out_ready`.
- R8: `clr_hist` high on an idle cycle zeroes x1, x2, y1 and y2 and keeps the coefficients and scale.
- R9: `coef_we` writes `coef_data` to b0, b1, b2, a1 or a2 for `coef_sel` 0, 1, 2, 3, 4. For `coef_sel`=5 it writes k from `coef_data[1:0]`. A write while `in_ready` is low is dropped.
- R10: After `rst`: `in_ready`=1, `out_valid`=0, `ovf`=0, and all coefficients, k and history are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Section idle, sample can be taken |
| in_data | input | 32 | Input sample |
| in_narrow | input | 1 | 1: sample is 16-bit in low half |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Reduced result, sign-extended |
| out_q23 | input | 1 | 1: 24-bit output, 0: 16-bit output |
| coef_we | input | 1 | Coefficient or scale write strobe |
| coef_sel | input | 3 | Write target (0..4 coefficients, 5 scale) |
| coef_data | input | 32 | Write value |
| clr_hist | input | 1 | Clear filter history |
| ovf | output | 1 | Sticky accumulator overflow |

## Verification
Directed single-tap patterns with known products pin down the fraction alignment and the restore shift for every scale value. Sequences of consecutive samples through all five taps expose wrong history movement or a wrong sign on the feedback terms. Extreme operands push both the accumulator and the output clamp to their limits, which tells saturation apart from wrap. Random coefficients, samples, modes and output back-pressure, with mid-computation writes and history clears mixed in, are compared against an exact arithmetic model of the section.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

    localparam int unsigned BQ_DATA_W   = 32;
    localparam int unsigned BQ_ACC_W    = 64;
    localparam int unsigned BQ_NARROW_W = 16;
    localparam int unsigned BQ_WIDE_W   = 24;
    localparam int unsigned BQ_SCALE_W  = 2;
    localparam int unsigned BQ_NTAPS    = 5;
    localparam int unsigned BQ_STEP_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_FIN,
        ST_OUT
    } bq_state_e;

    // Tap order doubles as write select and accumulate sequence
    typedef enum logic [BQ_STEP_W-1:0] {
        SEL_B0    = 3'd0,
        SEL_B1    = 3'd1,
        SEL_B2    = 3'd2,
        SEL_A1    = 3'd3,
        SEL_A2    = 3'd4,
        SEL_SCALE = 3'd5
    } bq_sel_e;

    typedef struct packed {
        logic                 start;
        logic                 step_en;
        logic [BQ_STEP_W-1:0] step;
        logic                 fin;
    } bq_ctrl_t;

    function automatic logic is_feedback(input logic [BQ_STEP_W-1:0] s);
        return s >= SEL_A1;
    endfunction

endpackage

// File: rtl/biquad_coef_bank.sv
module biquad_coef_bank
    import biquad_pkg::*;
#(
    parameter int DATA_W  = BQ_DATA_W,
    parameter int SCALE_W = BQ_SCALE_W,
    parameter int NTAPS   = BQ_NTAPS,
    parameter int SEL_W   = BQ_STEP_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NTAPS-1:0][DATA_W-1:0] coef,
    output logic [SCALE_W-1:0]           scale_k
);

    generate
        for (genvar i = 0; i < NTAPS; i++) begin : g_tap
            logic [DATA_W-1:0] tap_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tap_q <= '0;
                end else if (wr_en && wr_sel == SEL_W'(i)) begin
                    tap_q <= wr_data;
                end
            end
            assign coef[i] = tap_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_k <= '0;
        end else if (wr_en && wr_sel == SEL_W'(NTAPS)) begin
            scale_k <= wr_data[SCALE_W-1:0];
        end
    end

endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step_en,
    input  logic              subtract,
    input  logic [DATA_W-1:0] coef,
    input  logic [DATA_W-1:0] sample,
    output logic [ACC_W-1:0]  acc,
    output logic              ovf_sticky
);

    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = ACC_W + 2;

    logic signed [PROD_W-1:0] prod;
    logic signed [EXT_W-1:0]  term;
    logic signed [EXT_W-1:0]  sum;
    logic                     in_range;
    logic [ACC_W-1:0]         acc_nxt;

    assign prod = $signed(coef) * $signed(sample);

    always_comb begin
        term = EXT_W'(prod);
        if (subtract) begin
            term = -term;
        end
        sum      = EXT_W'($signed(acc)) + term;
        in_range = (&sum[EXT_W-1:ACC_W-1]) || (~|sum[EXT_W-1:ACC_W-1]);
        if (in_range) begin
            acc_nxt = sum[ACC_W-1:0];
        end else if (sum[EXT_W-1]) begin
            acc_nxt = {1'b1, {(ACC_W-1){1'b0}}};
        end else begin
            acc_nxt = {1'b0, {(ACC_W-1){1'b1}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            ovf_sticky <= 1'b0;
        end else if (clear) begin
            acc <= '0;
        end else if (step_en) begin
            acc <= acc_nxt;
            if (!in_range) begin
                ovf_sticky <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/biquad_out.sv
module biquad_out #(
    parameter int DATA_W   = 32,
    parameter int ACC_W    = 64,
    parameter int SCALE_W  = 2,
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 24
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic [SCALE_W-1:0] scale_k,
    input  logic               q23,
    output logic [DATA_W-1:0]  res,
    output logic [DATA_W-1:0]  reduced
);

    localparam int FRAC     = DATA_W - 1;
    localparam int DROP_NAR = DATA_W - NARROW_W;
    localparam int DROP_WID = DATA_W - WIDE_W;

    logic [7:0]              shamt;
    logic signed [ACC_W-1:0] shifted;
    logic                    fits;

    always_comb begin
        shamt   = 8'(FRAC) - 8'(scale_k);
        shifted = $signed(acc) >>> shamt;
        fits    = (&shifted[ACC_W-1:DATA_W-1]) || (~|shifted[ACC_W-1:DATA_W-1]);
        if (fits) begin
            res = shifted[DATA_W-1:0];
        end else if (shifted[ACC_W-1]) begin
            res = {1'b1, {(DATA_W-1){1'b0}}};
        end else begin
            res = {1'b0, {(DATA_W-1){1'b1}}};
        end
        if (q23) begin
            reduced = $signed(res) >>> DROP_WID;
        end else begin
            reduced = $signed(res) >>> DROP_NAR;
        end
    end

endmodule

// File: rtl/biquad_ctrl.sv
module biquad_ctrl
    import biquad_pkg::*;
#(
    parameter int NTAPS  = BQ_NTAPS,
    parameter int STEP_W = BQ_STEP_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  logic     out_ready,
    output logic     in_ready,
    output logic     out_valid,
    output bq_ctrl_t ctl
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NTAPS - 1);

    bq_state_e         state;
    logic [STEP_W-1:0] step;

    always_comb begin
        in_ready    = (state == ST_IDLE);
        out_valid   = (state == ST_OUT);
        ctl.start   = in_ready && in_valid;
        ctl.step_en = (state == ST_MAC);
        ctl.step    = step;
        ctl.fin     = (state == ST_FIN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_MAC;
                        step  <= '0;
                    end
                end
                ST_MAC: begin
                    if (step == LAST_STEP) begin
                        state <= ST_FIN;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                ST_FIN: state <= ST_OUT;
                ST_OUT: begin
                    if (out_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/biquad_section.sv
module biquad_section
    import biquad_pkg::*;
#(
    parameter int DATA_W   = BQ_DATA_W,
    parameter int ACC_W    = BQ_ACC_W,
    parameter int NARROW_W = BQ_NARROW_W,
    parameter int WIDE_W   = BQ_WIDE_W,
    parameter int SCALE_W  = BQ_SCALE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_narrow,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_q23,
    input  logic              coef_we,
    input  logic [2:0]        coef_sel,
    input  logic [DATA_W-1:0] coef_data,
    input  logic              clr_hist,
    output logic              ovf
);

    localparam int NTAPS  = BQ_NTAPS;
    localparam int STEP_W = BQ_STEP_W;
    localparam int PAD_W  = DATA_W - NARROW_W;

    bq_ctrl_t                    ctl;
    logic [NTAPS-1:0][DATA_W-1:0] coef_q;
    logic [SCALE_W-1:0]          scale_k;
    logic [DATA_W-1:0]           x0, x1, x2, y1, y2;
    logic                        q23_l;
    logic [DATA_W-1:0]           cur_coef, cur_sample;
    logic [ACC_W-1:0]            acc;
    logic [DATA_W-1:0]           res, reduced;
    logic [DATA_W-1:0]           out_q;
    logic [DATA_W-1:0]           entry_sample;

    biquad_ctrl #(.NTAPS(NTAPS), .STEP_W(STEP_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .ctl       (ctl)
    );

    biquad_coef_bank #(
        .DATA_W (DATA_W), .SCALE_W(SCALE_W), .NTAPS(NTAPS), .SEL_W(STEP_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (coef_we && in_ready),
        .wr_sel  (coef_sel),
        .wr_data (coef_data),
        .coef    (coef_q),
        .scale_k (scale_k)
    );

    always_comb begin
        unique case (ctl.step)
            SEL_B0:  begin cur_sample = x0; cur_coef = coef_q[0]; end
            SEL_B1:  begin cur_sample = x1; cur_coef = coef_q[1]; end
            SEL_B2:  begin cur_sample = x2; cur_coef = coef_q[2]; end
            SEL_A1:  begin cur_sample = y1; cur_coef = coef_q[3]; end
            default: begin cur_sample = y2; cur_coef = coef_q[4]; end
        endcase
    end

    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
        .clk        (clk),
        .rst        (rst),
        .clear      (ctl.start),
        .step_en    (ctl.step_en),
        .subtract   (is_feedback(ctl.step)),
        .coef       (cur_coef),
        .sample     (cur_sample),
        .acc        (acc),
        .ovf_sticky (ovf)
    );

    biquad_out #(
        .DATA_W(DATA_W), .ACC_W(ACC_W), .SCALE_W(SCALE_W),
        .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
    ) u_out (
        .acc     (acc),
        .scale_k (scale_k),
        .q23     (q23_l),
        .res     (res),
        .reduced (reduced)
    );

    assign entry_sample = in_narrow ? {in_data[NARROW_W-1:0], {PAD_W{1'b0}}} : in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            x0    <= '0;
            x1    <= '0;
            x2    <= '0;
            y1    <= '0;
            y2    <= '0;
            q23_l <= 1'b0;
            out_q <= '0;
        end else begin
            if (ctl.start) begin
                x0    <= entry_sample;
                q23_l <= out_q23;
            end
            if (clr_hist && in_ready) begin
                x1 <= '0;
                x2 <= '0;
                y1 <= '0;
                y2 <= '0;
            end else if (ctl.fin) begin
                x1    <= x0;
                x2    <= x1;
                y1    <= res;
                y2    <= y1;
            end
            if (ctl.fin) begin
                out_q <= reduced;
            end
        end
    end

    assign out_data = out_q;

endmodule

// File: rtl/biquad_section_chk.sv
module biquad_section_chk #(
    parameter int DATA_W  = 32,
    parameter int NTAPS   = 5,
    parameter int SCALE_W = 2,
    parameter int WIDE_W  = 24,
    parameter int NARROW_W = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_ready,
    input logic                         out_valid,
    input logic                         out_ready,
    input logic [DATA_W-1:0]            out_data,
    input logic                         ovf,
    input logic                         q23_l,
    input logic [NTAPS-1:0][DATA_W-1:0] coef_q,
    input logic [SCALE_W-1:0]           scale_k
);

    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid && !ovf));

    p_ready_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_return_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> in_ready);

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    p_coef_locked_r9: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> ($stable(coef_q) && $stable(scale_k)));

    p_reduce_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (q23_l ? ((&out_data[DATA_W-1:WIDE_W-1]) || (~|out_data[DATA_W-1:WIDE_W-1]))
                             : ((&out_data[DATA_W-1:NARROW_W-1]) || (~|out_data[DATA_W-1:NARROW_W-1]))));

endmodule

bind biquad_section biquad_section_chk #(
    .DATA_W(DATA_W), .NTAPS(NTAPS), .SCALE_W(SCALE_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .ovf       (ovf),
    .q23_l     (q23_l),
    .coef_q    (coef_q),
    .scale_k   (scale_k)
);

// File: tb/test_biquad_section.sv
module test_biquad_section;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        in_narrow = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        out_q23 = 1'b0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_sel = '0;
    logic [31:0] coef_data = '0;
    logic        clr_hist = 1'b0;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [31:0] mc [5];
    int          mk;
    logic [31:0] mx1, mx2, my1, my2;
    bit          movf;

    biquad_section i_biquad_section (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_narrow(in_narrow), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_q23(out_q23),
        .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
        .clr_hist(clr_hist), .ovf(ovf)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog: actual %0d cycles expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 5; i++) mc[i] = '0;
        mk = 0; mx1 = '0; mx2 = '0; my1 = '0; my2 = '0; movf = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
        model_clear();
    endtask

    task automatic wr_coef(input int sel, input logic [31:0] val);
        @(negedge clk);
        coef_we = 1'b1; coef_sel = 3'(sel); coef_data = val;
        @(negedge clk);
        coef_we = 1'b0;
        if (sel < 5) mc[sel] = val;
        else mk = int'(val[1:0]);
    endtask

    task automatic clear_hist();
        @(negedge clk); clr_hist = 1'b1;
        @(negedge clk); clr_hist = 1'b0;
        mx1 = '0; mx2 = '0; my1 = '0; my2 = '0;
    endtask

    // Exact arithmetic model of the section
    task automatic model(input logic [31:0] x0, input bit q23, output logic [31:0] exp_out);
        logic signed [65:0] a, t, s, amax, amin;
        logic [31:0] sm [5];
        longint r;
        logic [31:0] res;
        amax = 66'(64'sh7FFF_FFFF_FFFF_FFFF);
        amin = -amax - 66'sd1;
        sm[0] = x0; sm[1] = mx1; sm[2] = mx2; sm[3] = my1; sm[4] = my2;
        a = '0;
        for (int i = 0; i < 5; i++) begin
            t = 66'(longint'($signed(mc[i])) * longint'($signed(sm[i])));
            if (i >= 3) t = -t;
            s = a + t;
            if (s > amax) begin a = amax; movf = 1; end
            else if (s < amin) begin a = amin; movf = 1; end
            else a = s;
        end
        r = longint'(a[63:0]);
        r = r >>> (31 - mk);
        if (r > 64'sd2147483647) res = 32'h7FFF_FFFF;
        else if (r < -64'sd2147483648) res = 32'h8000_0000;
        else res = r[31:0];
        exp_out = q23 ? 32'($signed(res) >>> 8) : 32'($signed(res) >>> 16);
        mx2 = mx1; mx1 = x0; my2 = my1; my1 = res;
    endtask

    task automatic run_sample(input logic [31:0] d, input bit narrow, input bit q23,
                              input int hold, input bit poke);
        logic [31:0] x0, exp_out, first;
        int lat;
        x0 = narrow ? {d[15:0], 16'h0} : d;
        model(x0, q23, exp_out);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_narrow = narrow; out_q23 = q23;
        @(negedge clk);
        in_valid = 1'b0; in_data = $urandom; in_narrow = $urandom; out_q23 = $urandom;
        check(in_ready == 1'b0, "R7 busy after accept", 64'(in_ready), 64'd0);
        lat = 1;
        if (poke) begin
            coef_we = 1'b1; coef_sel = 3'd0; coef_data = $urandom;
            @(negedge clk);
            coef_we = 1'b1; coef_sel = 3'd5; coef_data = $urandom;
            @(negedge clk);
            coef_we = 1'b0;
            lat += 2;
        end
        while (!out_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 7, "R7 latency", 64'(lat), 64'd7);
        check(out_data == exp_out, narrow ? "R1 narrow result" : "R2 result",
              64'(out_data), 64'(exp_out));
        check(ovf == movf, "R3 ovf flag", 64'(ovf), 64'(movf));
        first = out_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(out_valid && out_data == first, "R7 hold", 64'(out_data), 64'(first));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check(!out_valid && in_ready, "R7 release", 64'({out_valid, in_ready}), 64'b01);
    endtask

    initial begin
        void'($urandom(32'd1357));
        model_clear();
        do_reset();
        check(in_ready == 1'b1, "R10 in_ready", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
        check(ovf == 1'b0, "R10 ovf", 64'(ovf), 64'd0);
        // R10: zero coefficients give zero output
        run_sample(32'h7000_0000, 0, 1, 0, 0);

        // R2: single tap alignment, then history through all taps (R6)
        wr_coef(0, 32'h4000_0000);
        run_sample(32'h2000_0000, 0, 1, 0, 0);
        wr_coef(1, 32'hE000_0000);
        wr_coef(2, 32'h1000_0000);
        wr_coef(3, 32'hC000_0000);
        wr_coef(4, 32'h2000_0000);
        run_sample(32'h1234_5678, 0, 0, 1, 0);
        run_sample(32'hF000_0000, 0, 1, 0, 0);
        run_sample(32'h0800_0000, 0, 0, 2, 0);   // R6 depends on y1/y2 feedback

        // R4: every scale value, including clamp at k=3
        for (int k = 0; k < 4; k++) begin
            wr_coef(5, 32'(k));
            run_sample(32'h3000_0000, 0, k[0], 0, 0);
            run_sample(32'h9000_0000, 0, k[1], 0, 0);
        end
        wr_coef(0, 32'h7FFF_FFFF);
        run_sample(32'h7FFF_FFFF, 0, 1, 0, 0);   // R4 positive clamp
        run_sample(32'h8000_0000, 0, 0, 0, 0);   // R4 negative clamp

        // R1: narrow input mode
        wr_coef(5, 32'd1);
        run_sample(32'hABCD_4321, 1, 1, 0, 0);
        run_sample(32'h0000_8001, 1, 0, 0, 0);

        // R9: writes while busy are dropped
        run_sample(32'h0100_0000, 0, 1, 0, 1);
        run_sample(32'hFF00_0000, 0, 1, 0, 0);

        // R8: history clear keeps coefficients
        clear_hist();
        run_sample(32'h0000_0000, 0, 1, 0, 0);
        check(out_data == 32'h0, "R8 cleared history", 64'(out_data), 64'd0);
        run_sample(32'h2222_0000, 0, 1, 0, 0);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            if (n % 25 == 0) begin
                for (int i = 0; i < 5; i++) begin
                    int v;
                    v = $urandom;
                    wr_coef(i, 32'(v >>> ($urandom % 4 + 1)));
                end
                wr_coef(5, $urandom);
            end
            if (n % 40 == 17) clear_hist();
            run_sample($urandom, $urandom % 4 == 0, $urandom, $urandom % 3, $urandom % 8 == 0);
        end

        // R3: accumulator overflow, sticky through history clear, cleared by reset
        do_reset();
        wr_coef(0, 32'h8000_0000);
        wr_coef(1, 32'h8000_0000);
        wr_coef(2, 32'h8000_0000);
        run_sample(32'h8000_0000, 0, 1, 0, 0);
        check(ovf == 1'b0, "R3 no overflow yet", 64'(ovf), 64'd0);
        run_sample(32'h8000_0000, 0, 1, 0, 0);
        run_sample(32'h8000_0000, 0, 0, 0, 0);
        check(ovf == 1'b1, "R3 overflow seen", 64'(ovf), 64'd1);
        clear_hist();
        check(ovf == 1'b1, "R3 sticky after clr_hist", 64'(ovf), 64'd1);
        do_reset();
        check(ovf == 1'b0, "R10 ovf cleared by reset", 64'(ovf), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule